// File: doc/BRIEF.md
# Intra 16x16 Prediction Mode Selector

This block picks the best of three whole-block intra predictors for a 16x16 tile of 8-bit luma samples. The three predictors are vertical, horizontal and DC. A start pulse captures a buffer of neighbouring reconstructed samples, an edge-availability field and a mode-enable mask. The source tile then streams in one 16-sample row per accepted handshake. While the rows arrive, the block accumulates the sum of absolute differences (SAD) against all three predictors in parallel, so the tile passes through only once.

After the sixteenth row, the block compares the costs of the enabled modes and uses a fixed tie order to choose one. It then presents the mode code and its cost. It then streams the sixteen rows of the winning prediction under valid/ready backpressure, and the final row is marked. An encoder front end uses the result in two ways: the cost feeds its mode decision, and the predicted rows feed residual formation.

Top module: `intra16_mode_picker`

## Requirements
- R1: `inReady` is low in reset and while idle. It rises on the cycle after an accepted `start`. Each cycle with `inValid` and `inReady` both high takes exactly one row, and `inReady` falls after the sixteenth row is taken.
- R2: Neighbour byte k sits at `nbrBuf[8k+7:8k]`, and the top edge left to right is bytes 17 to 32. Vertical prediction puts top byte 17+c in column c of every row, whatever the availability field says.
- R3: The left edge is stored bottom-up. Horizontal prediction fills row r with neighbour byte 15-r, whatever the availability field says. Byte 16 is never used.
- R4: In `availFlags`, bit 0 means the left edge is present and bit 2 means the top edge is present. The DC value equals the sum of the present edge bytes plus 8 per present edge, shifted right by 3 plus the count of present edges.
- R5: When `availFlags` is all zero, DC predicts 128 everywhere. When `availFlags` is non-zero but neither bit 0 nor bit 2 is set, DC predicts 0.
- R6: A mode's cost is the SAD over all 256 positions, ranging from 0 to 65280. `minCost` carries the cost of the chosen mode.
- R7: In `modeMask`, bit 0 enables vertical, bit 1 enables horizontal and bit 2 enables DC. A disabled mode costs 2^30 in the comparison.
- R8: Codes are 0 for vertical, 1 for horizontal and 2 for DC. Vertical wins when its cost is at most both other costs. Failing that, horizontal wins when its cost is at most the DC cost. DC wins otherwise.
- R9: `decisionValid` rises two cycles after the sixteenth row is taken. It stays high, with `modeCode` and `minCost` unchanged, until the last prediction row is accepted.
- R10: Prediction rows 0 to 15 are presented in order while `outValid` is high. A row advances only when `outReady` is high, and is held unchanged otherwise. `outLast` is high only with row 15. All outputs go low after that row is accepted.
- R11: A `start` that arrives while the block is collecting rows or emitting prediction rows has no effect on the latched neighbours, flags or sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tile; latches neighbours, flags and mask |
| nbrBuf | input | 264 | 33 neighbour bytes, byte k at bits 8k+7:8k |
| availFlags | input | 3 | Edge availability (bit 0 left, bit 2 top) |
| modeMask | input | 3 | Mode enables (bit 0 vertical, bit 1 horizontal, bit 2 DC) |
| inValid | input | 1 | Source row valid |
| inReady | output | 1 | Source row accepted when high with inValid |
| inRow | input | 128 | Source row, column c at bits 8c+7:8c |
| decisionValid | output | 1 | Mode and cost are valid |
| modeCode | output | 2 | Chosen mode code |
| minCost | output | 31 | Cost of the chosen mode |
| outValid | output | 1 | Prediction row valid |
| outReady | input | 1 | Consumer takes the prediction row |
| outRow | output | 128 | Prediction row, column c at bits 8c+7:8c |
| outLast | output | 1 | Marks prediction row 15 |

## Verification
A new `start` pulse can land on the same cycle as the handshake that hands over the last prediction row, when the sequencer is about to return to idle. The bench drives `start` on exactly that handshake and, in other runs, in the middle of row intake with altered neighbour bytes and flags on the inputs. The bench judges the outcome at the ports. After the final row, `inReady`, `outValid` and `decisionValid` must all be low, which shows that no new tile began. The predicted rows of the tile still in flight must match the neighbours captured at the original start.

// File: rtl/i16sel_pkg.sv
package i16sel_pkg;
  localparam int PIX_W      = 8;
  localparam int BLK_DIM    = 16;
  localparam int LOG_DIM    = $clog2(BLK_DIM);
  localparam int ROW_W      = PIX_W * BLK_DIM;
  localparam int NBR_CNT    = 2 * BLK_DIM + 1;
  localparam int NBR_W      = NBR_CNT * PIX_W;
  localparam int NBR_IDX_W  = $clog2(NBR_CNT);
  localparam int ROW_SAD_W  = PIX_W + LOG_DIM;
  localparam int SAD_W      = PIX_W + 2 * LOG_DIM + 1;
  localparam int EDGE_SUM_W = PIX_W + LOG_DIM + 2;
  localparam int COST_W     = 31;
  localparam int FLAG_W     = 3;
  localparam int TOP_BASE   = BLK_DIM + 1;
  localparam int AV_LEFT    = 0;
  localparam int AV_TOP     = 2;
  localparam int EN_VERT    = 0;
  localparam int EN_HORZ    = 1;
  localparam int EN_DC      = 2;
  localparam logic [COST_W-1:0] SENT_COST = COST_W'(1) << (COST_W - 1);
  localparam logic [COST_W-1:0] MAX_SAD   = COST_W'(BLK_DIM * BLK_DIM * ((1 << PIX_W) - 1));

  typedef enum logic [1:0] {
    MODE_VERT = 2'd0,
    MODE_HORZ = 2'd1,
    MODE_DC   = 2'd2
  } predMode_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_DECIDE,
    ST_EMIT
  } seqState_t;

  typedef struct packed {
    logic               load;
    logic               accum;
    logic               decide;
    logic [LOG_DIM-1:0] rowIdx;
  } dpStrobe_t;
endpackage

// File: rtl/i16sel_ctrl.sv
module i16sel_ctrl
  import i16sel_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      inValid,
  input  logic      outReady,
  output dpStrobe_t strobes,
  output logic      inReady,
  output logic      decisionValid,
  output logic      outValid,
  output logic      outLast
);
  localparam logic [LOG_DIM-1:0] LAST_IDX = LOG_DIM'(BLK_DIM - 1);

  seqState_t          state;
  logic [LOG_DIM-1:0] cnt;

  always_comb begin
    inReady        = (state == ST_COLLECT);
    outValid       = (state == ST_EMIT);
    decisionValid  = outValid;
    outLast        = outValid && (cnt == LAST_IDX);
    strobes.load   = (state == ST_IDLE) && start;
    strobes.accum  = inValid && inReady;
    strobes.decide = (state == ST_DECIDE);
    strobes.rowIdx = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_COLLECT;
            cnt   <= '0;
          end
        end
        ST_COLLECT: begin
          if (inValid) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_IDX) state <= ST_DECIDE;
          end
        end
        ST_DECIDE: state <= ST_EMIT;
        ST_EMIT: begin
          if (outReady) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_IDX) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: a start seen while emitting never begins a new intake
  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EMIT && start) |=> (state != ST_COLLECT));

  // R1: no row taken means the row counter holds
  p_row_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COLLECT && !inValid) |=> (state == ST_COLLECT) && $stable(cnt));
endmodule

// File: rtl/i16sel_datapath.sv
module i16sel_datapath
  import i16sel_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [NBR_W-1:0]  nbrBuf,
  input  logic [FLAG_W-1:0] availFlags,
  input  logic [FLAG_W-1:0] modeMask,
  input  logic [ROW_W-1:0]  inRow,
  output logic [1:0]        modeCode,
  output logic [COST_W-1:0] minCost,
  output logic [ROW_W-1:0]  outRow
);
  logic [NBR_W-1:0]  nbrVecQ;
  logic [FLAG_W-1:0] availQ, maskQ;
  logic [SAD_W-1:0]  sadV, sadH, sadD;
  predMode_t         modeQ;
  logic [COST_W-1:0] costQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nbrVecQ <= '0;
      availQ  <= '0;
      maskQ   <= '0;
    end else if (strobes.load) begin
      nbrVecQ <= nbrBuf;
      availQ  <= availFlags;
      maskQ   <= modeMask;
    end
  end

  function automatic logic [PIX_W-1:0] absDiff(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // DC value from the latched edges
  logic [EDGE_SUM_W-1:0] leftSum, topSum, dcSum, dcShifted;
  logic [1:0]            edgeCnt;
  logic                  useLeft, useTop;
  logic [PIX_W-1:0]      dcVal;

  always_comb begin
    leftSum = '0;
    topSum  = '0;
    for (int i = 0; i < BLK_DIM; i++) begin
      leftSum = leftSum + EDGE_SUM_W'(nbrVecQ[i*PIX_W +: PIX_W]);
      topSum  = topSum + EDGE_SUM_W'(nbrVecQ[(TOP_BASE+i)*PIX_W +: PIX_W]);
    end
    useLeft   = availQ[AV_LEFT];
    useTop    = availQ[AV_TOP];
    edgeCnt   = {1'b0, useLeft} + {1'b0, useTop};
    dcSum     = (useLeft ? leftSum : '0) + (useTop ? topSum : '0)
              + (EDGE_SUM_W'(edgeCnt) << (LOG_DIM - 1));
    dcShifted = dcSum >> (LOG_DIM - 1 + int'(edgeCnt));
    if (availQ == '0) dcVal = PIX_W'(1 << (PIX_W - 1));
    else              dcVal = dcShifted[PIX_W-1:0];
  end

  // Left pixel beside the current row (stored bottom-up)
  logic [NBR_IDX_W-1:0] leftIdx;
  logic [PIX_W-1:0]     leftPix;
  assign leftIdx = NBR_IDX_W'(BLK_DIM - 1) - NBR_IDX_W'(strobes.rowIdx);
  assign leftPix = nbrVecQ[leftIdx*PIX_W +: PIX_W];

  logic [PIX_W-1:0] diffV [BLK_DIM];
  logic [PIX_W-1:0] diffH [BLK_DIM];
  logic [PIX_W-1:0] diffD [BLK_DIM];

  for (genvar col = 0; col < BLK_DIM; col++) begin : g_col
    logic [PIX_W-1:0] srcPix, topPix;
    assign srcPix     = inRow[col*PIX_W +: PIX_W];
    assign topPix     = nbrVecQ[(TOP_BASE+col)*PIX_W +: PIX_W];
    assign diffV[col] = absDiff(srcPix, topPix);
    assign diffH[col] = absDiff(srcPix, leftPix);
    assign diffD[col] = absDiff(srcPix, dcVal);
    assign outRow[col*PIX_W +: PIX_W] = (modeQ == MODE_VERT) ? topPix :
                                        (modeQ == MODE_HORZ) ? leftPix : dcVal;
  end

  logic [ROW_SAD_W-1:0] rowV, rowH, rowD;
  always_comb begin
    rowV = '0;
    rowH = '0;
    rowD = '0;
    for (int c = 0; c < BLK_DIM; c++) begin
      rowV = rowV + ROW_SAD_W'(diffV[c]);
      rowH = rowH + ROW_SAD_W'(diffH[c]);
      rowD = rowD + ROW_SAD_W'(diffD[c]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sadV <= '0;
      sadH <= '0;
      sadD <= '0;
    end else if (strobes.load) begin
      sadV <= '0;
      sadH <= '0;
      sadD <= '0;
    end else if (strobes.accum) begin
      sadV <= sadV + SAD_W'(rowV);
      sadH <= sadH + SAD_W'(rowH);
      sadD <= sadD + SAD_W'(rowD);
    end
  end

  // Cost gating and fixed-order selection
  logic [COST_W-1:0] costV, costH, costD, bestCost;
  predMode_t         bestMode;
  always_comb begin
    costV = maskQ[EN_VERT] ? COST_W'(sadV) : SENT_COST;
    costH = maskQ[EN_HORZ] ? COST_W'(sadH) : SENT_COST;
    costD = maskQ[EN_DC]   ? COST_W'(sadD) : SENT_COST;
    if (costV <= costH && costV <= costD) begin
      bestMode = MODE_VERT;
      bestCost = costV;
    end else if (costH <= costD) begin
      bestMode = MODE_HORZ;
      bestCost = costH;
    end else begin
      bestMode = MODE_DC;
      bestCost = costD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_VERT;
      costQ <= '0;
    end else if (strobes.decide) begin
      modeQ <= bestMode;
      costQ <= bestCost;
    end
  end

  assign modeCode = modeQ;
  assign minCost  = costQ;

  // R6: accumulators start every tile from zero
  p_accum_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (sadV == '0) && (sadH == '0) && (sadD == '0));

  // R6: a recorded cost is either a real SAD or the sentinel
  p_cost_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decide |=> (costQ == SENT_COST) || (costQ <= MAX_SAD));

  // R7: with any mode enabled, the chosen one is enabled
  p_mode_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decide && maskQ != '0) |=> maskQ[modeCode]);
endmodule

// File: rtl/intra16_mode_picker.sv
module intra16_mode_picker
  import i16sel_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [NBR_W-1:0]  nbrBuf,
  input  logic [FLAG_W-1:0] availFlags,
  input  logic [FLAG_W-1:0] modeMask,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ROW_W-1:0]  inRow,
  output logic              decisionValid,
  output logic [1:0]        modeCode,
  output logic [COST_W-1:0] minCost,
  output logic              outValid,
  input  logic              outReady,
  output logic [ROW_W-1:0]  outRow,
  output logic              outLast
);
  dpStrobe_t strobes;

  i16sel_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .start         (start),
    .inValid       (inValid),
    .outReady      (outReady),
    .strobes       (strobes),
    .inReady       (inReady),
    .decisionValid (decisionValid),
    .outValid      (outValid),
    .outLast       (outLast)
  );

  i16sel_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .nbrBuf     (nbrBuf),
    .availFlags (availFlags),
    .modeMask   (modeMask),
    .inRow      (inRow),
    .modeCode   (modeCode),
    .minCost    (minCost),
    .outRow     (outRow)
  );

  // R10: a stalled prediction row holds
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outRow) && $stable(outLast));

  // R10: the last marker only accompanies a valid row
  p_last_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R9: the decision holds until the final row is taken
  p_decision_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && !(outLast && outReady)) |=>
      decisionValid && $stable(modeCode) && $stable(minCost));

  // R1: intake and emission never overlap
  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !outValid);
endmodule

// File: tb/sim_intra16_mode_picker.sv
module sim_intra16_mode_picker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int SENT       = 1 << 30;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [263:0] nbrBuf = '0;
  logic [2:0]   availFlags = '0;
  logic [2:0]   modeMask = '0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] inRow = '0;
  logic         decisionValid;
  logic [1:0]   modeCode;
  logic [30:0]  minCost;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [127:0] outRow;
  logic         outLast;

  intra16_mode_picker u0 (
    .clk(clk), .rstN(rstN), .start(start), .nbrBuf(nbrBuf),
    .availFlags(availFlags), .modeMask(modeMask), .inValid(inValid),
    .inReady(inReady), .inRow(inRow), .decisionValid(decisionValid),
    .modeCode(modeCode), .minCost(minCost), .outValid(outValid),
    .outReady(outReady), .outRow(outRow), .outLast(outLast)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [7:0] srcPix [16][16];
  logic [7:0] nbrB [33];
  logic [2:0] flags, mask;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      chk(1'b0, "R1 watchdog", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int refDc();
    int n = 0, s = 0;
    if (flags == 0) return 128;
    if (flags[0]) begin n++; for (int i = 0; i < 16; i++) s += nbrB[i]; end
    if (flags[2]) begin n++; for (int i = 0; i < 16; i++) s += nbrB[17 + i]; end
    return (s + 8 * n) >> (3 + n);
  endfunction

  function automatic int refPix(int mode, int r, int c);
    if (mode == 0) return nbrB[17 + c];
    if (mode == 1) return nbrB[15 - r];
    return refDc();
  endfunction

  function automatic int refSad(int mode);
    int s = 0;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        int d = int'(srcPix[r][c]) - refPix(mode, r, c);
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  function automatic logic [127:0] refRow(int mode, int r);
    logic [127:0] v;
    for (int c = 0; c < 16; c++) v[c*8 +: 8] = 8'(refPix(mode, r, c));
    return v;
  endfunction

  task automatic fillConst(input int s, input int n);
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) srcPix[r][c] = 8'(s);
    for (int i = 0; i < 33; i++) nbrB[i] = 8'(n);
  endtask

  task automatic fillRand();
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) srcPix[r][c] = 8'($urandom);
    for (int i = 0; i < 33; i++) nbrB[i] = 8'($urandom);
  endtask

  task automatic runBlock(input string modeTag, input bit stallOut, input bit gaps,
                          input bit startMid, input bit startAtEnd);
    int cv, ch, cd, expMode, expCost, r, k;
    string rowTag;
    cv = mask[0] ? refSad(0) : SENT;
    ch = mask[1] ? refSad(1) : SENT;
    cd = mask[2] ? refSad(2) : SENT;
    if (cv <= ch && cv <= cd) begin expMode = 0; expCost = cv; end
    else if (ch <= cd)        begin expMode = 1; expCost = ch; end
    else                      begin expMode = 2; expCost = cd; end
    rowTag = (expMode == 0) ? "R2" : (expMode == 1) ? "R3" :
             (flags[0] || flags[2]) ? "R4" : "R5";

    @(negedge clk);
    for (int i = 0; i < 33; i++) nbrBuf[i*8 +: 8] = nbrB[i];
    availFlags = flags;
    modeMask   = mask;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(inReady == 1'b1, "R1 ready after start", inReady, 1);

    r = 0;
    while (r < 16) begin
      bit acc;
      inValid = !(gaps && ($urandom % 3 == 0));
      for (int c = 0; c < 16; c++) inRow[c*8 +: 8] = srcPix[r][c];
      if (startMid && r == 5) begin
        start = 1'b1;
        nbrBuf = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        availFlags = 3'(~flags);
        modeMask = 3'(~mask);
      end
      acc = inValid && inReady;
      @(negedge clk);
      start = 1'b0;
      if (acc) r++;
    end
    inValid = 1'b0;
    chk(inReady == 1'b0 && decisionValid == 1'b0, "R1 intake closed", {inReady, decisionValid}, 0);
    @(negedge clk);
    chk(decisionValid == 1'b1, "R9 decision raised", decisionValid, 1);
    chk(modeCode == 2'(expMode), modeTag, modeCode, expMode);
    chk(minCost == 31'(expCost), "R6 cost", minCost, expCost);

    k = 0;
    while (k < 16) begin
      bit rdy = stallOut ? bit'($urandom % 2) : 1'b1;
      outReady = rdy;
      if (startAtEnd && k == 15 && rdy) begin
        start = 1'b1;
        availFlags = 3'($urandom);
      end
      chk(outValid == 1'b1 && outLast == (k == 15), "R10 valid/last", {outValid, outLast}, {1'b1, k == 15});
      chk(outRow == refRow(expMode, k), rowTag, outRow, refRow(expMode, k));
      chk(decisionValid && modeCode == 2'(expMode) && minCost == 31'(expCost), "R9 decision held",
          minCost, expCost);
      @(negedge clk);
      start = 1'b0;
      if (rdy) k++;
    end
    outReady = 1'b0;
    chk(!outValid && !inReady && !decisionValid, startAtEnd ? "R11 start at last row" : "R10 done",
        {outValid, inReady, decisionValid}, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(!inReady && !outValid && !decisionValid, "R1 reset state", {inReady, outValid, decisionValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!inReady && !outValid, "R1 idle state", {inReady, outValid}, 0);

    // R8: three-way tie of zero costs picks vertical
    fillConst(0, 0); flags = 3'b101; mask = 3'b111;
    runBlock("R8 tie all", 0, 0, 0, 0);
    // R8: horizontal beats DC on a tie when vertical is off
    mask = 3'b110;
    runBlock("R8 tie horz dc", 1, 0, 0, 0);
    // R7: nothing enabled gives sentinel and vertical
    fillRand(); mask = 3'b000;
    runBlock("R7 none enabled", 0, 1, 0, 0);
    // R5: no flags gives 128
    flags = 3'b000; mask = 3'b100;
    runBlock("R5 dc 128", 0, 0, 0, 1);
    // R5: middle flag only gives 0
    flags = 3'b010; mask = 3'b100;
    runBlock("R5 dc zero", 1, 1, 0, 0);
    // R6: largest SAD
    fillConst(255, 0); flags = 3'b101; mask = 3'b011;
    runBlock("R6 max sad", 0, 0, 0, 0);
    // R4: each edge alone and both, DC forced
    fillRand(); flags = 3'b001; mask = 3'b100;
    runBlock("R4 left only", 0, 0, 1, 0);
    flags = 3'b100;
    runBlock("R4 top only", 1, 0, 0, 1);
    // R2 and R3 with edges flagged absent
    flags = 3'b000; mask = 3'b001;
    runBlock("R7 vert only", 0, 1, 0, 0);
    mask = 3'b010;
    runBlock("R7 horz only", 1, 0, 1, 0);

    for (int t = 0; t < 10; t++) begin
      fillRand();
      flags = 3'($urandom); mask = 3'($urandom);
      runBlock("R8 random", bit'($urandom), bit'($urandom), bit'($urandom), bit'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule